// File: doc/BRIEF.md
# Invalidation Acknowledgement Accounting Unit

This block keeps, for every outstanding transaction entry of a cache line controller, a signed count of the invalidation acknowledgements that a request for write permission still waits for. Acknowledgements from peer caches and the directory's data reply can arrive in either order. The data reply carries the number of acknowledgements to expect. An early acknowledgement therefore drives the count below zero, and the data reply later adds its carried number back in.

Each incoming response names a transaction entry, says whether it came from the directory or from a peer cache, and gives its kind. The unit sorts it into one event for the line controller: directory data with nothing pending, directory data with acknowledgements still pending, an ordinary acknowledgement, the last acknowledgement, or data from the owning peer. Malformed or impossible responses raise an error strobe instead and leave the count untouched. Separate strobes allocate and free entries, and both clear the count. Data payloads never pass through the block.

Top module: `ackacc_unit`

## Requirements
- R1: After reset `evt_vld` and `err_vld` are low and no entry is allocated, so a response to any entry raises `err_vld`.
- R2: Allocating an entry sets its counter to zero and marks it allocated. A directory data reply (`rsp_from_dir`=1, `rsp_kind`=0) carrying zero acks then yields event code 1.
- R3: A peer inv-ack (`rsp_from_dir`=0, `rsp_kind`=1) on an allocated entry whose counter is not 1 and not -MAX_SHARERS yields event code 3 and decrements the counter. The counter may go negative.
- R4: A directory data reply whose carried count plus the counter equals zero yields event code 1 and leaves the counter at zero.
- R5: A directory data reply whose sum lies in 1..MAX_SHARERS yields event code 2 and stores the sum in the counter. The counter always stays within -MAX_SHARERS..MAX_SHARERS.
- R6: A peer inv-ack arriving while the counter equals exactly 1 yields event code 4 (never 3) and sets the counter to zero.
- R7: A peer data reply (`rsp_from_dir`=0, `rsp_kind`=0) yields event code 5 whatever the counter holds, and leaves the counter unchanged.
- R8: `err_vld` rises with no event, and the counter does not change, in any of these cases: the entry is unallocated; a directory response is not data; a directory sum is negative or above MAX_SHARERS; a peer response has a reserved kind (2 or 3); a peer inv-ack arrives when the counter is -MAX_SHARERS.
- R9: Freeing an entry clears its counter and marks it unallocated, so later responses to it raise `err_vld`.
- R10: A response's result appears exactly one clock after `rsp_vld`, with `evt_idx` equal to the response's entry. `evt_vld` and `err_vld` are never high together, and both are low one clock after a cycle without `rsp_vld`.
- R11: A response is classified on the entry's state before the edge. An allocate or free of the same entry in the same cycle overrides the response's counter update, and allocate wins over free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocate strobe |
| alloc_idx | input | IDX_W | Entry to allocate |
| free_vld | input | 1 | Free strobe |
| free_idx | input | IDX_W | Entry to free |
| rsp_vld | input | 1 | Incoming response valid |
| rsp_idx | input | IDX_W | Entry the response belongs to |
| rsp_from_dir | input | 1 | 1 = sent by the directory, 0 = sent by a peer cache |
| rsp_kind | input | 2 | 0 = data, 1 = inv-ack, 2/3 reserved |
| rsp_acks | input | ACK_W | Ack count carried by directory data |
| evt_vld | output | 1 | Classified event valid |
| evt_code | output | 3 | 1 data/no acks, 2 data/acks pending, 3 ack, 4 last ack, 5 owner data |
| evt_idx | output | IDX_W | Entry of the reported result |
| err_vld | output | 1 | Response rejected |

## Verification
Every result, whether an event or an error, is registered once and appears on the clock edge that samples `rsp_vld`. Allocate and free take effect on that same edge. The bench drives each stimulus half a period before an edge and compares all four outputs half a period after it, before it drives the next stimulus. After a cycle without a response it checks that both strobes are low. Counter values show only through later events, so each directed sequence ends with a response whose class depends on the exact count left behind.

// File: rtl/ackacc_pkg.sv
package ackacc_pkg;

   typedef enum logic [2:0] {
      EV_NONE       = 3'd0,
      EV_DATA_NOACK = 3'd1,
      EV_DATA_ACKS  = 3'd2,
      EV_INV_ACK    = 3'd3,
      EV_LAST_ACK   = 3'd4,
      EV_OWNER_DATA = 3'd5
   } ackacc_evt_e;

   typedef enum logic [1:0] {
      RK_DATA   = 2'd0,
      RK_INVACK = 2'd1,
      RK_RSV2   = 2'd2,
      RK_RSV3   = 2'd3
   } ackacc_kind_e;

endpackage

// File: rtl/ackacc_classify.sv
module ackacc_classify
   import ackacc_pkg::*;
#(
   parameter int MAX_SHARERS = 15,
   parameter int ACK_W       = $clog2(MAX_SHARERS + 1),
   parameter int CNT_W       = ACK_W + 1
) (
   input  logic                    cur_valid,
   input  logic        [CNT_W-1:0] cur_cnt,
   input  logic                    from_dir,
   input  logic        [1:0]       kind,
   input  logic        [ACK_W-1:0] acks,
   output logic        [2:0]       code,
   output logic                    err,
   output logic                    wr_en,
   output logic        [CNT_W-1:0] nxt_cnt
);
   localparam int SUM_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
   localparam logic [CNT_W-1:0] FLOOR_C = CNT_W'(-MAX_SHARERS);
   localparam logic signed [SUM_W-1:0] CEIL_S = SUM_W'(MAX_SHARERS);

   logic signed [SUM_W-1:0] acks_ext;
   logic signed [SUM_W-1:0] cnt_ext;
   logic signed [SUM_W-1:0] sum;

   assign acks_ext = $signed({{(SUM_W-ACK_W){1'b0}}, acks});
   assign cnt_ext  = $signed({cur_cnt[CNT_W-1], cur_cnt});
   assign sum      = acks_ext + cnt_ext;

   always_comb begin
      code    = EV_NONE;
      err     = 1'b0;
      wr_en   = 1'b0;
      nxt_cnt = cur_cnt;
      if (!cur_valid) begin
         err = 1'b1;
      end else if (from_dir) begin
         if (kind != RK_DATA) begin
            err = 1'b1;
         end else if (sum < 0 || sum > CEIL_S) begin
            err = 1'b1;
         end else if (sum == 0) begin
            code    = EV_DATA_NOACK;
            wr_en   = 1'b1;
            nxt_cnt = '0;
         end else begin
            code    = EV_DATA_ACKS;
            wr_en   = 1'b1;
            nxt_cnt = sum[CNT_W-1:0];
         end
      end else begin
         unique case (kind)
            RK_DATA: code = EV_OWNER_DATA;
            RK_INVACK: begin
               if (cur_cnt == ONE_C) begin
                  code    = EV_LAST_ACK;
                  wr_en   = 1'b1;
                  nxt_cnt = '0;
               end else if (cur_cnt == FLOOR_C) begin
                  err = 1'b1;
               end else begin
                  code    = EV_INV_ACK;
                  wr_en   = 1'b1;
                  nxt_cnt = cur_cnt - ONE_C;
               end
            end
            default: err = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/ackacc_entry_bank.sv
module ackacc_entry_bank #(
   parameter int NUM_ENTRIES = 8,
   parameter int CNT_W       = 5,
   parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              alloc_vld,
   input  logic [IDX_W-1:0]                  alloc_idx,
   input  logic                              free_vld,
   input  logic [IDX_W-1:0]                  free_idx,
   input  logic                              upd_vld,
   input  logic [IDX_W-1:0]                  upd_idx,
   input  logic [CNT_W-1:0]                  upd_cnt,
   output logic [NUM_ENTRIES-1:0]            valid_q,
   output logic [NUM_ENTRIES-1:0][CNT_W-1:0] cnt_q
);
   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic hit_alloc, hit_free, hit_upd;
      assign hit_alloc = alloc_vld && (alloc_idx == IDX_W'(e));
      assign hit_free  = free_vld  && (free_idx  == IDX_W'(e));
      assign hit_upd   = upd_vld   && (upd_idx   == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            cnt_q[e]   <= '0;
         end else if (hit_alloc) begin
            valid_q[e] <= 1'b1;
            cnt_q[e]   <= '0;
         end else if (hit_free) begin
            valid_q[e] <= 1'b0;
            cnt_q[e]   <= '0;
         end else if (hit_upd) begin
            cnt_q[e]   <= upd_cnt;
         end
      end
   end
endmodule

// File: rtl/ackacc_unit.sv
module ackacc_unit
   import ackacc_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int MAX_SHARERS = 15,
   parameter bit REG_OUT     = 1'b1,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
   localparam int ACK_W      = $clog2(MAX_SHARERS + 1),
   localparam int CNT_W      = ACK_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_vld,
   input  logic [IDX_W-1:0] alloc_idx,
   input  logic             free_vld,
   input  logic [IDX_W-1:0] free_idx,
   input  logic             rsp_vld,
   input  logic [IDX_W-1:0] rsp_idx,
   input  logic             rsp_from_dir,
   input  logic [1:0]       rsp_kind,
   input  logic [ACK_W-1:0] rsp_acks,
   output logic             evt_vld,
   output logic [2:0]       evt_code,
   output logic [IDX_W-1:0] evt_idx,
   output logic             err_vld
);
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 1024) begin : g_bad_entries
      $error("ackacc_unit: NUM_ENTRIES out of range");
   end
   if (MAX_SHARERS < 1 || MAX_SHARERS > 4096) begin : g_bad_sharers
      $error("ackacc_unit: MAX_SHARERS out of range");
   end

   logic [NUM_ENTRIES-1:0]            ent_valid;
   logic [NUM_ENTRIES-1:0][CNT_W-1:0] ent_cnt;
   logic             idx_ok;
   logic             sel_valid;
   logic [CNT_W-1:0] sel_cnt;
   logic [2:0]       c_code;
   logic             c_err;
   logic             c_wr;
   logic [CNT_W-1:0] c_nxt;

   assign idx_ok    = (32'(rsp_idx) < NUM_ENTRIES);
   assign sel_valid = idx_ok && ent_valid[rsp_idx];
   assign sel_cnt   = idx_ok ? ent_cnt[rsp_idx] : '0;

   ackacc_classify #(
      .MAX_SHARERS(MAX_SHARERS), .ACK_W(ACK_W), .CNT_W(CNT_W)
   ) u_cls (
      .cur_valid(sel_valid), .cur_cnt(sel_cnt), .from_dir(rsp_from_dir),
      .kind(rsp_kind), .acks(rsp_acks), .code(c_code), .err(c_err),
      .wr_en(c_wr), .nxt_cnt(c_nxt)
   );

   ackacc_entry_bank #(
      .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
      .free_vld(free_vld), .free_idx(free_idx),
      .upd_vld(rsp_vld && c_wr), .upd_idx(rsp_idx), .upd_cnt(c_nxt),
      .valid_q(ent_valid), .cnt_q(ent_cnt)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            evt_vld  <= 1'b0;
            evt_code <= EV_NONE;
            evt_idx  <= '0;
            err_vld  <= 1'b0;
         end else begin
            evt_vld  <= rsp_vld && !c_err;
            evt_code <= (rsp_vld && !c_err) ? c_code : EV_NONE;
            evt_idx  <= rsp_vld ? rsp_idx : evt_idx;
            err_vld  <= rsp_vld && c_err;
         end
      end
   end else begin : g_comb_out
      assign evt_vld  = rsp_vld && !c_err;
      assign evt_code = (rsp_vld && !c_err) ? c_code : EV_NONE;
      assign evt_idx  = rsp_idx;
      assign err_vld  = rsp_vld && c_err;
   end
endmodule

// File: rtl/ackacc_unit_chk.sv
module ackacc_unit_chk #(
   parameter int NUM_ENTRIES = 8,
   parameter int MAX_SHARERS = 15,
   parameter bit REG_OUT     = 1'b1,
   parameter int IDX_W       = 3,
   parameter int CNT_W       = 5
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              rsp_vld,
   input logic [IDX_W-1:0]                  rsp_idx,
   input logic                              rsp_from_dir,
   input logic [1:0]                        rsp_kind,
   input logic                              alloc_vld,
   input logic                              free_vld,
   input logic                              evt_vld,
   input logic [2:0]                        evt_code,
   input logic [IDX_W-1:0]                  evt_idx,
   input logic                              err_vld,
   input logic [NUM_ENTRIES-1:0]            ent_valid,
   input logic [NUM_ENTRIES-1:0][CNT_W-1:0] ent_cnt
);
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_vld && err_vld));

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_bound
      p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ($signed(ent_cnt[e]) >= -MAX_SHARERS) &&
         ($signed(ent_cnt[e]) <= MAX_SHARERS));
   end

   if (REG_OUT) begin : g_seq
      p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rsp_vld |=> (!evt_vld && !err_vld));
      p_idx_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_vld |=> (evt_idx == $past(rsp_idx)));
      p_unalloc_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_vld && (32'(rsp_idx) < NUM_ENTRIES) && !ent_valid[rsp_idx])
         |=> err_vld);
      p_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_vld && !rsp_from_dir && rsp_kind == 2'd0 &&
          (32'(rsp_idx) < NUM_ENTRIES) && ent_valid[rsp_idx])
         |=> (evt_vld && evt_code == 3'd5));
      p_last_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_vld && evt_code == 3'd4 && !$past(alloc_vld) &&
          !$past(free_vld)) |-> (ent_cnt[evt_idx] == '0));
   end
endmodule

bind ackacc_unit ackacc_unit_chk #(
   .NUM_ENTRIES(NUM_ENTRIES), .MAX_SHARERS(MAX_SHARERS), .REG_OUT(REG_OUT),
   .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rsp_vld(rsp_vld), .rsp_idx(rsp_idx),
   .rsp_from_dir(rsp_from_dir), .rsp_kind(rsp_kind),
   .alloc_vld(alloc_vld), .free_vld(free_vld),
   .evt_vld(evt_vld), .evt_code(evt_code), .evt_idx(evt_idx),
   .err_vld(err_vld), .ent_valid(ent_valid), .ent_cnt(ent_cnt)
);

// File: tb/ackacc_unit_tb.sv
`timescale 1ns/1ps
module ackacc_unit_tb;
   localparam int N     = 8;
   localparam int MAXS  = 15;
   localparam int IDX_W = 3;
   localparam int ACK_W = 4;
   localparam real HALF = 10.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_vld = 0, free_vld = 0, rsp_vld = 0, rsp_from_dir = 0;
   logic [IDX_W-1:0] alloc_idx = '0, free_idx = '0, rsp_idx = '0;
   logic [1:0] rsp_kind = '0;
   logic [ACK_W-1:0] rsp_acks = '0;
   logic evt_vld, err_vld;
   logic [2:0] evt_code;
   logic [IDX_W-1:0] evt_idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit m_val [N];
   int m_cnt [N];

   always #(HALF) clk = ~clk;

   ackacc_unit #(.NUM_ENTRIES(N), .MAX_SHARERS(MAXS)) u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
      .free_vld(free_vld), .free_idx(free_idx), .rsp_vld(rsp_vld),
      .rsp_idx(rsp_idx), .rsp_from_dir(rsp_from_dir), .rsp_kind(rsp_kind),
      .rsp_acks(rsp_acks), .evt_vld(evt_vld), .evt_code(evt_code),
      .evt_idx(evt_idx), .err_vld(err_vld)
   );

   // Expected result from the requirements; updates the model counter.
   function automatic void predict(input int idx, input bit dir, input int kind,
                                   input int acks, output int code,
                                   output bit err, output string tag);
      int s;
      code = 0; err = 0; tag = "R8";
      if (!m_val[idx]) begin err = 1; return; end
      if (dir) begin
         s = acks + m_cnt[idx];
         if (kind != 0 || s < 0 || s > MAXS) err = 1;
         else if (s == 0) begin code = 1; m_cnt[idx] = 0; tag = "R4"; end
         else begin code = 2; m_cnt[idx] = s; tag = "R5"; end
      end else if (kind == 0) begin
         code = 5; tag = "R7";
      end else if (kind == 1) begin
         if (m_cnt[idx] == 1) begin code = 4; m_cnt[idx] = 0; tag = "R6"; end
         else if (m_cnt[idx] == -MAXS) err = 1;
         else begin code = 3; m_cnt[idx] = m_cnt[idx] - 1; tag = "R3"; end
      end else err = 1;
   endfunction

   // Called at a falling edge; drives, crosses one rising edge, checks.
   task automatic step(input bit al, input int ai, input bit fr, input int fi,
                       input bit rv, input int ri, input bit dir, input int kind,
                       input int acks, input string tag_in);
      int ecode; bit eerr; string tag;
      alloc_vld = al; alloc_idx = IDX_W'(ai);
      free_vld = fr; free_idx = IDX_W'(fi);
      rsp_vld = rv; rsp_idx = IDX_W'(ri); rsp_from_dir = dir;
      rsp_kind = 2'(kind); rsp_acks = ACK_W'(acks);
      ecode = 0; eerr = 0; tag = "R10";
      if (rv) predict(ri, dir, kind, acks, ecode, eerr, tag);
      if (tag_in != "") tag = tag_in;
      if (fr) begin m_val[fi] = 0; m_cnt[fi] = 0; end
      if (al) begin m_val[ai] = 1; m_cnt[ai] = 0; end
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (evt_vld !== (rv && !eerr) || err_vld !== (rv && eerr) ||
          evt_code !== 3'(rv && !eerr ? ecode : 0) ||
          (rv && evt_idx !== IDX_W'(ri))) begin
         errors++;
         $display("FAIL %s: vld=%0b code=%0d idx=%0d err=%0b expected vld=%0b code=%0d idx=%0d err=%0b",
                  tag, evt_vld, evt_code, evt_idx, err_vld,
                  rv && !eerr, rv && !eerr ? ecode : 0, ri, rv && eerr);
      end
   endtask

   task automatic rsp(input int idx, input bit dir, input int kind, input int acks,
                      input string tag);
      step(0, 0, 0, 0, 1, idx, dir, kind, acks, tag);
   endtask

   task automatic alloc(input int idx);
      step(1, idx, 0, 0, 0, 0, 0, 0, 0, "R10");
   endtask

   initial begin
      #(HALF * 2.0 * 200000.0);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: expired expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_cnt[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (evt_vld !== 1'b0 || err_vld !== 1'b0) begin
         errors++;
         $display("FAIL R1: vld=%0b err=%0b expected 0 0", evt_vld, err_vld);
      end
      for (int i = 0; i < N; i++) rsp(i, 1, 0, 0, "R1");

      alloc(0);
      rsp(0, 1, 0, 0, "R2");
      // early acks, then data, then last ack
      alloc(1);
      rsp(1, 0, 1, 0, "R3");
      rsp(1, 0, 1, 0, "R3");
      rsp(1, 1, 0, 3, "R5");
      rsp(1, 0, 1, 0, "R6");
      rsp(1, 1, 0, 0, "R4");
      rsp(1, 0, 2, 0, "R8");
      // data first, then acks
      alloc(2);
      rsp(2, 1, 0, 2, "R5");
      rsp(2, 0, 0, 0, "R7");
      rsp(2, 0, 1, 0, "R3");
      rsp(2, 0, 1, 0, "R6");
      rsp(2, 1, 1, 0, "R8");
      // negative sum, counter floor, sum above ceiling
      alloc(3);
      rsp(3, 0, 1, 0, "R3");
      rsp(3, 1, 0, 0, "R8");
      for (int k = 0; k < MAXS - 1; k++) rsp(3, 0, 1, 0, "R3");
      rsp(3, 0, 1, 0, "R8");
      rsp(3, 1, 0, MAXS, "R4");
      rsp(3, 1, 0, MAXS, "R5");
      rsp(3, 1, 0, 1, "R8");
      step(0, 0, 1, 3, 0, 0, 0, 0, 0, "R9");
      rsp(3, 0, 0, 0, "R9");
      // same-cycle allocate / free with a response
      alloc(4);
      rsp(4, 0, 1, 0, "R3");
      step(1, 4, 0, 0, 1, 4, 0, 1, 0, "R11");
      rsp(4, 1, 0, 1, "R11");
      alloc(5);
      step(0, 0, 1, 5, 1, 5, 0, 0, 0, "R11");
      rsp(5, 0, 0, 0, "R11");

      void'($urandom(32'h5eed1234));
      for (int n = 0; n < 3000; n++) begin
         int op, idx, kind, acks; bit dir;
         op = $urandom_range(0, 9);
         idx = $urandom_range(0, N - 1);
         if (op < 2) alloc(idx);
         else if (op == 2) step(0, 0, 1, idx, 0, 0, 0, 0, 0, "R9");
         else begin
            dir = ($urandom_range(0, 9) < 4);
            if (dir) kind = ($urandom_range(0, 9) == 0) ? 1 : 0;
            else begin
               kind = $urandom_range(0, 19);
               kind = (kind < 6) ? 0 : (kind < 19) ? 1 : $urandom_range(2, 3);
            end
            acks = $urandom_range(0, MAXS);
            if (dir && m_val[idx] && m_cnt[idx] <= 0 && $urandom_range(0, 1) == 1)
               acks = -m_cnt[idx];
            rsp(idx, dir, kind, acks, "");
         end
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule